// File: doc/BRIEF.md
# Peripheral-to-Pad Routing Multiplexer

This block decides, for each of 99 general-purpose pads, which source drives the pad and which peripheral sees the pad's input level. Four kinds of owner compete for a pad: an I/O processor override bit per pad, three fixed pad groups (a serial flash group with two alternative pad sets, a two-pin UART0 group and a ten-pin eMMC group), a full crossbar in which any of 120 peripheral signals can be steered to any of the 64 pads numbered 8 to 71, and plain GPIO as the fallback.

Software loads the routing through a one-word write port. Each crossbar signal has its own select register whose value v (1 to 64) places the signal on pad v + 7; value 0 leaves it unrouted. The multiplexing itself is combinational, so only the configuration registers add latency.

Top module: `pad_route_mux`

## Requirements
- R1: In the cycle after reset is released, every pad is owned by GPIO: pad_out and pad_oe equal gpio_out and gpio_oe for every pad, all select, group and override registers read as zero.
- R2: A crossbar select value v in 1..64 for signal s drives pad v+7 with sig_out[s] and sig_oe[s] (v=3 gives pad 10, v=20 gives pad 27, v=64 gives pad 71).
- R3: A select value of 0 or above 64 routes nothing: the pad stays with its lower-priority owner and sig_in of that signal reads its idle level.
- R4: A routed signal reads the level of its pad on sig_in while the crossbar owns that pad. Signal numbering: s<16 is UART(s/4+1) with s%4 = 0 TX, 1 RX, 2 RTS, 3 CTS; s=16..19 are I2C0 clock, I2C0 data, I2C1 clock, I2C1 data. Idle level is 1 for RX, CTS and the four I2C lines, 0 for every other signal.
- R5: When several signals select the same pad, the lowest-numbered one drives it and xbar_conflict is 1; otherwise xbar_conflict is 0.
- R6: Flash group field 1 gives pads 83, 84, 86, 87 to group slots 0..3; field 2 gives pads 76, 78, 79, 81 to slots 0..3; field 0 or 3 claims nothing.
- R7: UART0 enable gives pad 88 to slot 4 (TX) and pad 89 to slot 5 (RX); slot 5 idles at 1 when it does not own its pad.
- R8: eMMC enable gives pads 72..81 to slots 6..15; where the flash group claims the same pad, the flash slot wins and the losing eMMC slot reads 0.
- R9: A set override bit gives the pad to the I/O processor (iop_out, iop_oe) ahead of every other owner.
- R10: Pad priority is override, then group, then crossbar, then GPIO; a peripheral input (sig_in, grp_in) reads its pad only while it owns that pad, otherwise its idle level (group slots other than 5 idle at 0).
- R11: Register map on wr_addr: 0..119 select of signal s in wr_data[6:0]; 120 group word with wr_data[1:0] flash field, wr_data[2] UART0 enable, wr_data[3] eMMC enable; 128+p override bit of pad p in wr_data[0]; every other address is ignored.
- R12: A write takes effect at the clock edge that samples wr_en; outputs before that edge still show the old routing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Configuration write strobe |
| wr_addr | input | 8 | Configuration register address |
| wr_data | input | 8 | Configuration write data |
| gpio_out | input | 99 | GPIO output level per pad |
| gpio_oe | input | 99 | GPIO output enable per pad |
| iop_out | input | 99 | I/O processor output level per pad |
| iop_oe | input | 99 | I/O processor output enable per pad |
| sig_out | input | 120 | Crossbar peripheral output levels |
| sig_oe | input | 120 | Crossbar peripheral output enables |
| sig_in | output | 120 | Crossbar peripheral input levels |
| grp_out | input | 16 | Group slot output levels |
| grp_oe | input | 16 | Group slot output enables |
| grp_in | output | 16 | Group slot input levels |
| pad_in | input | 99 | Level seen at each pad |
| pad_out | output | 99 | Level driven to each pad |
| pad_oe | output | 99 | Output enable driven to each pad |
| xbar_conflict | output | 1 | Two or more crossbar signals select one pad |

## Verification
Every result of this block is combinational from its inputs and its configuration registers, so a change of gpio, iop, peripheral or pad levels is due in the same cycle and a configuration write is due in the cycle after the edge that samples it. The bench changes inputs only on the falling edge, queues the expected values in that same cycle and compares them three nanoseconds later, before the next rising edge. For the write latency it queues the old value while the strobe is still pending and the new value one cycle later.

// File: rtl/pmx_pkg.sv
// Shared types and constant functions for the pad routing multiplexer.
// Assumes at least 20 crossbar signals (UART1..4 and I2C0/1 lead the list)
// and 16 fixed group slots: flash 0..3, UART0 4..5, eMMC 6..15.
package pmx_pkg;

    localparam int GRP_SLOTS = 16;

    typedef enum logic [1:0] {
        OWN_GPIO = 2'd0,
        OWN_XBAR = 2'd1,
        OWN_GRP  = 2'd2,
        OWN_IOP  = 2'd3
    } pad_owner_e;

    typedef struct packed {
        logic       emmc_en;
        logic       uart0_en;
        logic [1:0] flash_sel;
    } grp_cfg_t;

    // Idle level of an unrouted crossbar signal: receive/clear-to-send and I2C high.
    function automatic logic sig_idle_high(int s);
        if (s < 16) return (s % 4 == 1) || (s % 4 == 3);
        if (s < 20) return 1'b1;
        return 1'b0;
    endfunction

    // Pad index claimed by a group slot for a given flash field, -1 for none.
    function automatic int grp_slot_pad(int k, logic [1:0] flash_sel);
        int r;
        r = -1;
        if (k < 4) begin
            if (flash_sel == 2'd1) begin
                case (k)
                    0: r = 83;
                    1: r = 84;
                    2: r = 86;
                    default: r = 87;
                endcase
            end else if (flash_sel == 2'd2) begin
                case (k)
                    0: r = 76;
                    1: r = 78;
                    2: r = 79;
                    default: r = 81;
                endcase
            end
        end else if (k < 6) begin
            r = 84 + k;
        end else begin
            r = 66 + k;
        end
        return r;
    endfunction

    // Whether the group owning slot k is enabled.
    function automatic logic grp_slot_en(int k, grp_cfg_t cfg);
        if (k < 4) return (cfg.flash_sel == 2'd1) || (cfg.flash_sel == 2'd2);
        if (k < 6) return cfg.uart0_en;
        return cfg.emmc_en;
    endfunction

    // Idle input level of a group slot: only the UART0 receive slot idles high.
    function automatic logic grp_slot_idle(int k);
        return (k == 5);
    endfunction

endpackage

// File: rtl/pmx_cfg_regs.sv
// Configuration registers of the pad routing multiplexer.
// Holds one crossbar select per signal, the group word and one override bit
// per pad. Writes land on the clock edge that samples wr_en; unmapped
// addresses are dropped. Assumes NUM_SIG < IOP_BASE.
module pmx_cfg_regs
    import pmx_pkg::*;
#(
    parameter int NUM_SIG  = 120,
    parameter int NUM_PADS = 99,
    parameter int SEL_W    = 7,
    parameter int ADDR_W   = 8,
    parameter int DATA_W   = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [DATA_W-1:0]   wr_data,
    output logic [SEL_W-1:0]    sel [NUM_SIG],
    output grp_cfg_t            grp,
    output logic [NUM_PADS-1:0] iop_sel
);

    localparam int GRP_ADDR = NUM_SIG;
    localparam int IOP_BASE = 2 ** (ADDR_W - 1);

    int addr_i;
    assign addr_i = int'(wr_addr);

    // Register file update: reset clears, a write updates one decoded entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < NUM_SIG; s++) sel[s] <= '0;
            grp     <= '0;
            iop_sel <= '0;
        end else if (wr_en) begin
            if (addr_i < NUM_SIG) begin
                sel[addr_i] <= wr_data[SEL_W-1:0];
            end else if (addr_i == GRP_ADDR) begin
                grp <= grp_cfg_t'(wr_data[3:0]);
            end else if (addr_i >= IOP_BASE && addr_i < IOP_BASE + NUM_PADS) begin
                iop_sel[addr_i - IOP_BASE] <= wr_data[0];
            end
        end
    end

    // R1: configuration is cleared when reset is released.
    p_reset_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (grp == '0) && (iop_sel == '0) && (sel[0] == '0));

    // R11: a group-word write is visible after the sampling edge.
    p_grp_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr_i == GRP_ADDR) |=> (grp == grp_cfg_t'($past(wr_data[3:0]))));

    // R11: writes into the address hole change neither group nor overrides.
    p_hole_ignored_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr_i > GRP_ADDR && addr_i < IOP_BASE) |=> ($stable(grp) && $stable(iop_sel)));

endmodule

// File: rtl/pmx_xbar.sv
// Full crossbar between peripheral signals and the crossbar-capable pads.
// Output side: for each crossbar pad the lowest-numbered signal whose select
// code equals pad+1 drives it; a second match raises conflict.
// Input side: a signal reads its pad only while the arbiter grants that pad
// to the crossbar, otherwise its idle level.
module pmx_xbar
    import pmx_pkg::*;
#(
    parameter int NUM_SIG   = 120,
    parameter int XBAR_PADS = 64,
    parameter int SEL_W     = 7
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [SEL_W-1:0]     sel [NUM_SIG],
    input  logic [NUM_SIG-1:0]   sig_out,
    input  logic [NUM_SIG-1:0]   sig_oe,
    output logic [NUM_SIG-1:0]   sig_in,
    input  logic [XBAR_PADS-1:0] xpad_in,
    input  logic [XBAR_PADS-1:0] xpad_own,
    output logic [XBAR_PADS-1:0] xpad_hit,
    output logic [XBAR_PADS-1:0] xpad_out,
    output logic [XBAR_PADS-1:0] xpad_oe,
    output logic                 conflict
);

    // Pad drive selection: scan high to low so the lowest signal index wins.
    always_comb begin
        xpad_hit = '0;
        xpad_out = '0;
        xpad_oe  = '0;
        conflict = 1'b0;
        for (int p = 0; p < XBAR_PADS; p++) begin
            for (int s = NUM_SIG - 1; s >= 0; s--) begin
                if (sel[s] == SEL_W'(p + 1)) begin
                    if (xpad_hit[p]) conflict = 1'b1;
                    xpad_hit[p] = 1'b1;
                    xpad_out[p] = sig_out[s];
                    xpad_oe[p]  = sig_oe[s];
                end
            end
        end
    end

    // Signal input return: pad level when routed and granted, idle otherwise.
    always_comb begin
        for (int s = 0; s < NUM_SIG; s++) begin
            sig_in[s] = sig_idle_high(s);
            if (sel[s] != '0 && int'(sel[s]) <= XBAR_PADS) begin
                if (xpad_own[int'(sel[s]) - 1]) sig_in[s] = xpad_in[int'(sel[s]) - 1];
            end
        end
    end

    // R3: an unrouted signal always reads its idle level.
    for (genvar s = 0; s < NUM_SIG; s++) begin : g_idle_chk
        localparam logic IDLE = sig_idle_high(s);
        p_unrouted_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (sel[s] == '0) |-> (sig_in[s] == IDLE));
    end

    // R5: a conflict implies at least one crossbar pad is driven.
    p_conflict_has_pad_r5: assert property (@(posedge clk) disable iff (!rst_n)
        conflict |-> (xpad_hit != '0));

    // R2: signal 0 routed to pad index 2 of the crossbar drives it when alone.
    p_route_sig0_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (sel[0] == SEL_W'(3)) |-> (xpad_hit[2] && xpad_out[2] == sig_out[0] && xpad_oe[2] == sig_oe[0]));

endmodule

// File: rtl/pmx_pad_arbiter.sv
// Per-pad ownership and final output multiplexing.
// Resolves each pad to override, group, crossbar or GPIO in that order,
// muxes the winner onto pad_out/pad_oe, and returns pad levels to group
// slots that own their pad. Within groups the lower slot wins a shared pad.
module pmx_pad_arbiter
    import pmx_pkg::*;
#(
    parameter int NUM_PADS  = 99,
    parameter int XBAR_BASE = 8,
    parameter int XBAR_PADS = 64
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  grp_cfg_t             grp,
    input  logic [NUM_PADS-1:0]  iop_sel,
    input  logic [NUM_PADS-1:0]  iop_out,
    input  logic [NUM_PADS-1:0]  iop_oe,
    input  logic [NUM_PADS-1:0]  gpio_out,
    input  logic [NUM_PADS-1:0]  gpio_oe,
    input  logic [XBAR_PADS-1:0] xpad_hit,
    input  logic [XBAR_PADS-1:0] xpad_out,
    input  logic [XBAR_PADS-1:0] xpad_oe,
    output logic [XBAR_PADS-1:0] xpad_own,
    input  logic [GRP_SLOTS-1:0] grp_out,
    input  logic [GRP_SLOTS-1:0] grp_oe,
    output logic [GRP_SLOTS-1:0] grp_in,
    input  logic [NUM_PADS-1:0]  pad_in,
    output logic [NUM_PADS-1:0]  pad_out,
    output logic [NUM_PADS-1:0]  pad_oe
);

    localparam int SLOT_W = $clog2(GRP_SLOTS);

    logic [NUM_PADS-1:0]       gclaim;
    logic [SLOT_W-1:0]         gslot [NUM_PADS];
    logic [NUM_PADS-1:0][1:0]  owner_vec;

    // Group claim map: scan slots high to low so the lowest slot keeps a pad.
    always_comb begin
        gclaim = '0;
        for (int p = 0; p < NUM_PADS; p++) gslot[p] = '0;
        for (int k = GRP_SLOTS - 1; k >= 0; k--) begin
            if (grp_slot_en(k, grp)) begin
                if (grp_slot_pad(k, grp.flash_sel) >= 0 && grp_slot_pad(k, grp.flash_sel) < NUM_PADS) begin
                    gclaim[grp_slot_pad(k, grp.flash_sel)] = 1'b1;
                    gslot[grp_slot_pad(k, grp.flash_sel)]  = SLOT_W'(k);
                end
            end
        end
    end

    for (genvar p = 0; p < NUM_PADS; p++) begin : g_pad
        logic       xhit, xo, xoe;
        pad_owner_e own;

        if (p >= XBAR_BASE && p < XBAR_BASE + XBAR_PADS) begin : g_xbar
            assign xhit = xpad_hit[p - XBAR_BASE];
            assign xo   = xpad_out[p - XBAR_BASE];
            assign xoe  = xpad_oe[p - XBAR_BASE];
            assign xpad_own[p - XBAR_BASE] = (own == OWN_XBAR);
        end else begin : g_plain
            assign xhit = 1'b0;
            assign xo   = 1'b0;
            assign xoe  = 1'b0;
        end

        // Owner resolution in fixed priority order.
        always_comb begin
            if (iop_sel[p])     own = OWN_IOP;
            else if (gclaim[p]) own = OWN_GRP;
            else if (xhit)      own = OWN_XBAR;
            else                own = OWN_GPIO;
        end

        assign owner_vec[p] = own;

        // Output mux: route the owner's data and enable onto the pad.
        always_comb begin
            case (own)
                OWN_IOP:  begin pad_out[p] = iop_out[p];       pad_oe[p] = iop_oe[p];       end
                OWN_GRP:  begin pad_out[p] = grp_out[gslot[p]]; pad_oe[p] = grp_oe[gslot[p]]; end
                OWN_XBAR: begin pad_out[p] = xo;               pad_oe[p] = xoe;             end
                default:  begin pad_out[p] = gpio_out[p];      pad_oe[p] = gpio_oe[p];      end
            endcase
        end

        // R9: an override bit hands the pad to the I/O processor.
        p_iop_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
            iop_sel[p] |-> (pad_out[p] == iop_out[p] && pad_oe[p] == iop_oe[p]));

        // R10: a pad is group-owned only while some group is enabled.
        p_grp_needs_en_r10: assert property (@(posedge clk) disable iff (!rst_n)
            (owner_vec[p] == OWN_GRP) |-> (grp.uart0_en || grp.emmc_en ||
                                           grp.flash_sel == 2'd1 || grp.flash_sel == 2'd2));
    end

    // Group input return: pad level only to the slot that owns the pad.
    always_comb begin
        for (int k = 0; k < GRP_SLOTS; k++) begin
            grp_in[k] = grp_slot_idle(k);
            if (grp_slot_en(k, grp)) begin
                if (grp_slot_pad(k, grp.flash_sel) >= 0 && grp_slot_pad(k, grp.flash_sel) < NUM_PADS) begin
                    if (owner_vec[grp_slot_pad(k, grp.flash_sel)] == OWN_GRP &&
                        gslot[grp_slot_pad(k, grp.flash_sel)] == SLOT_W'(k))
                        grp_in[k] = pad_in[grp_slot_pad(k, grp.flash_sel)];
                end
            end
        end
    end

    // R8: with flash set 2 and eMMC both on, the eMMC slot on pad 76 reads 0.
    p_emmc_loses_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (grp.emmc_en && grp.flash_sel == 2'd2) |-> (grp_in[10] == 1'b0));

    // R7: UART0 receive slot idles high while the group is off.
    p_uart0_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !grp.uart0_en |-> grp_in[5]);

endmodule

// File: rtl/pad_route_mux.sv
// Top of the peripheral-to-pad routing multiplexer.
// Connects the configuration registers, the crossbar and the per-pad
// arbiter. All routing is combinational from configuration and inputs;
// only configuration writes are registered.
module pad_route_mux
    import pmx_pkg::*;
#(
    parameter int NUM_PADS  = 99,
    parameter int NUM_SIG   = 120,
    parameter int XBAR_BASE = 8,
    parameter int XBAR_PADS = 64,
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    wr_addr,
    input  logic [DATA_W-1:0]    wr_data,
    input  logic [NUM_PADS-1:0]  gpio_out,
    input  logic [NUM_PADS-1:0]  gpio_oe,
    input  logic [NUM_PADS-1:0]  iop_out,
    input  logic [NUM_PADS-1:0]  iop_oe,
    input  logic [NUM_SIG-1:0]   sig_out,
    input  logic [NUM_SIG-1:0]   sig_oe,
    output logic [NUM_SIG-1:0]   sig_in,
    input  logic [GRP_SLOTS-1:0] grp_out,
    input  logic [GRP_SLOTS-1:0] grp_oe,
    output logic [GRP_SLOTS-1:0] grp_in,
    input  logic [NUM_PADS-1:0]  pad_in,
    output logic [NUM_PADS-1:0]  pad_out,
    output logic [NUM_PADS-1:0]  pad_oe,
    output logic                 xbar_conflict
);

    localparam int SEL_W = $clog2(XBAR_PADS + 1);

    logic [SEL_W-1:0]     sel [NUM_SIG];
    grp_cfg_t             grp;
    logic [NUM_PADS-1:0]  iop_sel;
    logic [XBAR_PADS-1:0] xpad_hit, xpad_out, xpad_oe, xpad_own;

    pmx_cfg_regs #(
        .NUM_SIG(NUM_SIG), .NUM_PADS(NUM_PADS), .SEL_W(SEL_W),
        .ADDR_W(ADDR_W), .DATA_W(DATA_W)
    ) i_cfg (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .sel(sel), .grp(grp), .iop_sel(iop_sel)
    );

    pmx_xbar #(
        .NUM_SIG(NUM_SIG), .XBAR_PADS(XBAR_PADS), .SEL_W(SEL_W)
    ) i_xbar (
        .clk(clk), .rst_n(rst_n), .sel(sel), .sig_out(sig_out), .sig_oe(sig_oe),
        .sig_in(sig_in), .xpad_in(pad_in[XBAR_BASE +: XBAR_PADS]), .xpad_own(xpad_own),
        .xpad_hit(xpad_hit), .xpad_out(xpad_out), .xpad_oe(xpad_oe),
        .conflict(xbar_conflict)
    );

    pmx_pad_arbiter #(
        .NUM_PADS(NUM_PADS), .XBAR_BASE(XBAR_BASE), .XBAR_PADS(XBAR_PADS)
    ) i_arb (
        .clk(clk), .rst_n(rst_n), .grp(grp), .iop_sel(iop_sel),
        .iop_out(iop_out), .iop_oe(iop_oe), .gpio_out(gpio_out), .gpio_oe(gpio_oe),
        .xpad_hit(xpad_hit), .xpad_out(xpad_out), .xpad_oe(xpad_oe), .xpad_own(xpad_own),
        .grp_out(grp_out), .grp_oe(grp_oe), .grp_in(grp_in),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
    );

endmodule

// File: tb/test_pad_route_mux.sv
// Scoreboard bench: the driver queues expected values in the cycle it sets
// the stimulus; the monitor compares them 3 ns after each falling edge.
module test_pad_route_mux;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic [98:0] gpio_out = '0, gpio_oe = '0, iop_out = '0, iop_oe = '0, pad_in = '0;
    logic [119:0] sig_out = '0, sig_oe = '0;
    logic [15:0] grp_out = '0, grp_oe = '0;
    logic [119:0] sig_in;
    logic [15:0] grp_in;
    logic [98:0] pad_out, pad_oe;
    logic        xbar_conflict;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        int    kind;   // 0 pad_out, 1 pad_oe, 2 sig_in, 3 grp_in, 4 conflict
        int    idx;
        logic  exp;
        string req;
    } item_t;

    item_t q[$];

    always #5 clk = ~clk;

    pad_route_mux i_pad_route_mux (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .gpio_out(gpio_out), .gpio_oe(gpio_oe), .iop_out(iop_out), .iop_oe(iop_oe),
        .sig_out(sig_out), .sig_oe(sig_oe), .sig_in(sig_in),
        .grp_out(grp_out), .grp_oe(grp_oe), .grp_in(grp_in),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .xbar_conflict(xbar_conflict)
    );

    task automatic expect_bit(int kind, int idx, logic exp, string req);
        item_t it;
        it.kind = kind; it.idx = idx; it.exp = exp; it.req = req;
        q.push_back(it);
    endtask

    task automatic cfg_write(int addr, int data);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 8'(addr); wr_data = 8'(data);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    // Monitor: compares every queued item 3 ns after the falling edge.
    initial begin
        forever begin
            @(negedge clk);
            #3;
            while (q.size() > 0) begin
                item_t it;
                logic  act;
                it = q.pop_front();
                case (it.kind)
                    0: act = pad_out[it.idx];
                    1: act = pad_oe[it.idx];
                    2: act = sig_in[it.idx];
                    3: act = grp_in[it.idx];
                    default: act = xbar_conflict;
                endcase
                checks++;
                if (act !== it.exp) begin
                    errors++;
                    $display("FAIL %s kind=%0d idx=%0d actual=%b expected=%b",
                             it.req, it.kind, it.idx, act, it.exp);
                end
            end
        end
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        #2000000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // Driver.
    initial begin
        gpio_out = {33{3'b101}};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state: GPIO owns every pad.
        expect_bit(1, 0, 1'b0, "R1");
        expect_bit(1, 10, 1'b0, "R1");
        expect_bit(1, 98, 1'b0, "R1");
        expect_bit(0, 98, gpio_out[98], "R1");
        expect_bit(0, 97, gpio_out[97], "R1");
        expect_bit(4, 0, 1'b0, "R5");
        // R4 idle levels after reset
        expect_bit(2, 0, 1'b0, "R4");
        expect_bit(2, 1, 1'b1, "R4");
        expect_bit(2, 3, 1'b1, "R4");
        expect_bit(2, 16, 1'b1, "R4");
        expect_bit(2, 30, 1'b0, "R4");
        expect_bit(3, 5, 1'b1, "R7");
        expect_bit(3, 0, 1'b0, "R10");
        step();

        // R12: old routing before the sampling edge, new routing after it.
        sig_out[0] = 1'b1; sig_oe[0] = 1'b1; gpio_out[10] = 1'b0;
        wr_en = 1'b1; wr_addr = 8'd0; wr_data = 8'd3;
        expect_bit(0, 10, 1'b0, "R12");
        expect_bit(1, 10, 1'b0, "R12");
        step();
        wr_en = 1'b0;
        expect_bit(0, 10, 1'b1, "R12");
        // R2 code 3 -> pad 10
        expect_bit(1, 10, 1'b1, "R2");
        step();

        // R2 code 20 -> pad 27 for I2C0 clock
        cfg_write(16, 20);
        sig_out[16] = 1'b0; sig_oe[16] = 1'b1; gpio_out[27] = 1'b1;
        expect_bit(0, 27, 1'b0, "R2");
        expect_bit(1, 27, 1'b1, "R2");
        step();
        // R2 code 64 -> pad 71
        cfg_write(5, 64);
        sig_out[5] = 1'b1; sig_oe[5] = 1'b1; gpio_out[71] = 1'b0;
        expect_bit(0, 71, 1'b1, "R2");
        expect_bit(1, 71, 1'b1, "R2");
        step();

        // R4 input routing: UART1 RX code 4 -> pad 11
        cfg_write(1, 4);
        pad_in[11] = 1'b0;
        expect_bit(2, 1, 1'b0, "R4");
        step();
        pad_in[11] = 1'b1;
        expect_bit(2, 1, 1'b1, "R4");
        step();

        // R3 code 65 is out of range: pad 72 stays GPIO, signal idles.
        cfg_write(2, 65);
        gpio_oe[72] = 1'b0; sig_oe[2] = 1'b1; pad_in[72] = 1'b1;
        expect_bit(1, 72, 1'b0, "R3");
        expect_bit(2, 2, 1'b0, "R3");
        step();
        // R3 code 0 releases pad 10 back to GPIO
        cfg_write(0, 0);
        gpio_oe[10] = 1'b0;
        expect_bit(1, 10, 1'b0, "R3");
        expect_bit(0, 10, 1'b0, "R3");
        step();

        // R5 conflict on pad 37 (code 30): lower index drives it.
        cfg_write(40, 30);
        cfg_write(41, 30);
        sig_out[40] = 1'b1; sig_out[41] = 1'b0; sig_oe[40] = 1'b1; sig_oe[41] = 1'b1;
        expect_bit(0, 37, 1'b1, "R5");
        expect_bit(4, 0, 1'b1, "R5");
        step();
        cfg_write(40, 0);
        expect_bit(0, 37, 1'b0, "R5");
        expect_bit(4, 0, 1'b0, "R5");
        step();

        // R6 flash set 1: pads 83, 84, 86, 87
        cfg_write(120, 1);
        grp_out[3:0] = 4'b0101; grp_oe[3:0] = 4'b1111; pad_in[84] = 1'b1;
        expect_bit(0, 83, 1'b1, "R6");
        expect_bit(0, 84, 1'b0, "R6");
        expect_bit(0, 86, 1'b1, "R6");
        expect_bit(1, 87, 1'b1, "R6");
        expect_bit(1, 85, 1'b0, "R6");
        expect_bit(3, 1, 1'b1, "R6");
        step();
        // R6 flash set 2: pads 76, 78, 79, 81; pad 83 back to GPIO
        cfg_write(120, 2);
        grp_out[3:0] = 4'b1010;
        expect_bit(0, 76, 1'b0, "R6");
        expect_bit(0, 78, 1'b1, "R6");
        expect_bit(0, 81, 1'b1, "R6");
        expect_bit(1, 83, 1'b0, "R6");
        step();

        // R7 UART0 group: pad 88 TX, pad 89 RX
        cfg_write(120, 4);
        grp_out[4] = 1'b1; grp_oe[4] = 1'b1; pad_in[89] = 1'b0;
        expect_bit(0, 88, 1'b1, "R7");
        expect_bit(1, 88, 1'b1, "R7");
        expect_bit(3, 5, 1'b0, "R7");
        step();
        cfg_write(120, 0);
        expect_bit(3, 5, 1'b1, "R7");
        expect_bit(1, 88, 1'b0, "R7");
        step();

        // R8 eMMC plus flash set 2: flash slot keeps pad 76.
        cfg_write(120, 8 + 2);
        grp_out = 16'h0041; grp_oe = 16'hFFFF; pad_in[76] = 1'b1; pad_in[72] = 1'b1;
        expect_bit(0, 72, 1'b1, "R8");
        expect_bit(0, 76, 1'b1, "R8");
        expect_bit(0, 77, 1'b0, "R8");
        expect_bit(3, 0, 1'b1, "R8");
        expect_bit(3, 10, 1'b0, "R8");
        expect_bit(3, 6, 1'b1, "R8");
        step();

        // R9 override beats crossbar (pad 10), group (pad 76) and GPIO (pad 0).
        cfg_write(0, 3);
        cfg_write(128 + 10, 1);
        cfg_write(128 + 76, 1);
        cfg_write(128 + 0, 1);
        iop_out[10] = 1'b0; iop_oe[10] = 1'b1; sig_out[0] = 1'b1;
        iop_out[76] = 1'b0; iop_oe[76] = 1'b0;
        iop_out[0] = 1'b0; iop_oe[0] = 1'b1; gpio_out[0] = 1'b1;
        expect_bit(0, 10, 1'b0, "R9");
        expect_bit(1, 10, 1'b1, "R9");
        expect_bit(0, 76, 1'b0, "R9");
        expect_bit(1, 0, 1'b1, "R9");
        expect_bit(3, 0, 1'b0, "R10");
        step();
        // R10 crossbar input loses its pad to the override: idle level returns.
        cfg_write(128 + 11, 1);
        pad_in[11] = 1'b0;
        expect_bit(2, 1, 1'b1, "R10");
        step();

        // R11 unmapped addresses are ignored.
        cfg_write(125, 255);
        cfg_write(227, 1);
        iop_out[98] = ~gpio_out[98];
        expect_bit(0, 98, gpio_out[98], "R11");
        expect_bit(0, 88, gpio_out[88], "R11");
        expect_bit(0, 72, 1'b1, "R11");
        step();
        step();

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule